// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller for a 10-bit successive-approximation converter that serves eight multiplexed analog inputs. Software writes two control bytes: one holds the enable, start/busy, channel, reference and justification fields, and the other holds the conversion-clock choice. When a conversion is started, the block latches the channel and the clock choice. It derives a conversion tick from the system clock or from a separate free-running clock, and it runs a frame of exactly eleven tick periods.

The first period of the frame holds the sampled voltage. Each of the next ten periods resolves one result bit, starting at the most significant bit. During each of these periods the block presents a trial code to an external DAC and reads one comparator bit back. At the end of the frame it stores the result, clears the busy flag and raises a one-cycle done pulse. The stored result is shown across a high/low byte pair in either left or right justification.

Top module: `adc_sar_ctrl`

## Requirements
- R1: Control byte A (address 0) has these fields: bit 0 enable, bit 1 start/busy, bits 4:2 channel, bit 6 reference select, bit 7 justification, with bit 5 reading 0. Control byte B (address 1) has the clock select in bits 6:4, and its other bits read 0. After reset every control and result output is 0.
- R2: Writing byte A with bits 0 and 1 both set while idle starts a conversion, and bit 1 reads 1 from the next cycle on.
- R3: A start request written with bit 0 clear is ignored: bit 1 stays 0 and no conversion completes.
- R4: The clock-select codes 000, 100, 001, 101, 010 and 110 divide the system clock by 2, 4, 8, 16, 32 and 64. A conversion in one of these modes takes exactly 11 × N system cycles, counted from the write edge to the cycle in which done is high.
- R5: Codes 011 and 111 both time the frame from rising edges of the free-running clock input (rc_clk_i), and a conversion spans 11 of its periods plus synchronizer latency.
- R6: The result equals the analog code. This holds when the comparator reports 1 whenever the input is at or above dac_code_o and the bits are resolved MSB first: the first trial code is 0x200, and the second trial code is 0x100 or 0x300.
- R7: dac_code_o is 0 during the first (hold) period of the frame.
- R8: With justification 1, res_hi_o = {6'b0, r[9:8]} and res_lo_o = r[7:0].
- R9: With justification 0, res_hi_o = r[9:2] and res_lo_o = {r[1:0], 6'b0}.
- R10: A write to byte A during a conversion with bit 0 or bit 1 clear aborts the conversion. Busy drops in the next cycle, no done pulse follows, and the result bytes keep their values.
- R11: mux_sel_o takes the channel at the start of a conversion. Channel writes made while busy do not change it or the conversion, although byte A reads back the new field.
- R12: vref_sel_o follows bit 6 of byte A.
- R13: done_o is high for exactly one cycle. In that cycle busy already reads 0 and the new result is visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rc_clk_i | input | 1 | Free-running conversion clock, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = control byte A, 1 = control byte B |
| wr_data_i | input | 8 | Write data |
| ctrl_a_o | output | 8 | Read-back of control byte A |
| ctrl_b_o | output | 8 | Read-back of control byte B |
| res_hi_o | output | 8 | Result high byte |
| res_lo_o | output | 8 | Result low byte |
| done_o | output | 1 | One-cycle conversion-complete pulse |
| mux_sel_o | output | 3 | Latched channel to the analog multiplexer |
| vref_sel_o | output | 1 | Reference select to the analog front end |
| dac_code_o | output | 10 | Trial code to the DAC |
| comp_i | input | 1 | Comparator output, 1 when input ≥ DAC voltage |

## Verification
The hardest states to reach are the ones inside a running frame: an abort or a channel rewrite that lands partway through, and the trial code held during a specific period. The bench reaches them by counting system cycles from the start write in the slowest divider mode, so that it knows exactly which period is active. It then samples dac_code_o in the hold period and in the first two bit periods, and it issues the mid-frame writes at known offsets. The comparator is modelled from per-channel input codes, so every completed frame has an exact expected result, which the bench queues at the start.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;
  localparam int RES_W     = 10;
  localparam int REG_W     = 8;
  localparam int CH_W      = 3;
  localparam int CS_W      = 3;
  localparam int MAX_SHIFT = 6;

  typedef struct packed {
    logic            just;
    logic            vref;
    logic            rsv;
    logic [CH_W-1:0] ch;
    logic            go;
    logic            en;
  } ctrl_a_t;

  // {hi, lo}: right-justified zero-extends, left-justified shifts up
  function automatic logic [2*REG_W-1:0] place_result(input logic [RES_W-1:0] r,
                                                      input logic right);
    logic [2*REG_W-1:0] v;
    v = {{(2*REG_W-RES_W){1'b0}}, r};
    return right ? v : (v << (2*REG_W-RES_W));
  endfunction
endpackage

// File: rtl/adc_clk_gen.sv
module adc_clk_gen #(
  parameter int MAX_SHIFT = 6,
  parameter int CS_W      = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [CS_W-1:0] sel_i,
  input  logic            rc_clk_i,
  output logic            tick_o
);
  localparam int CNT_W = MAX_SHIFT;

  logic [2:0]       rc_sync_q;
  logic [CNT_W-1:0] cnt_q, lim;
  logic [2:0]       shift;
  logic             use_rc, rc_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rc_sync_q <= '0;
    else         rc_sync_q <= {rc_sync_q[1:0], rc_clk_i};
  end
  assign rc_rise = rc_sync_q[1] & ~rc_sync_q[2];

  // low two bits pick the octave pair, top bit picks the odd step
  assign use_rc = (sel_i[1:0] == 2'b11);
  assign shift  = 3'd1 + {sel_i[1:0], 1'b0} + {2'b00, sel_i[2]};
  assign lim    = CNT_W'((32'd1 << shift) - 32'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (cnt_q == lim) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i & (use_rc ? rc_rise : (cnt_q == lim));

  p_tick_spaced_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !use_rc) |=> !tick_o);
endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine #(
  parameter int RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             tick_i,
  input  logic             comp_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] dac_code_o,
  output logic [RES_W-1:0] result_o
);
  localparam int PER_W = $clog2(RES_W + 1);

  logic [PER_W-1:0] per_q;
  logic [RES_W-1:0] sar_q, result_q, trial_bit, trial;
  logic             busy_q, done_q;

  // period 0 holds; period k tests bit RES_W-k
  assign trial_bit = (busy_q && per_q != '0) ? (RES_W'(1) << (RES_W - int'(per_q))) : '0;
  assign trial     = sar_q | trial_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q    <= '0;
      sar_q    <= '0;
      result_q <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        per_q  <= '0;
        sar_q  <= '0;
      end else if (busy_q && abort_i) begin
        busy_q <= 1'b0;
      end else if (busy_q && tick_i) begin
        if (per_q != '0 && comp_i) sar_q <= trial;
        if (per_q == PER_W'(RES_W)) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          result_q <= comp_i ? trial : sar_q;
        end else begin
          per_q <= per_q + 1'b1;
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign dac_code_o = busy_q ? trial : '0;
  assign result_o   = result_q;

  p_done_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_after_busy_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!busy_q && $past(busy_q)));
  p_result_on_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_q) |-> done_q);
  p_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && abort_i && !start_i) |=> (!busy_q && !done_q));
  p_frame_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (per_q <= PER_W'(RES_W)));
endmodule

// File: rtl/adc_sar_ctrl.sv
module adc_sar_ctrl
  import adc_sar_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rc_clk_i,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] ctrl_a_o,
  output logic [REG_W-1:0] ctrl_b_o,
  output logic [REG_W-1:0] res_hi_o,
  output logic [REG_W-1:0] res_lo_o,
  output logic             done_o,
  output logic [CH_W-1:0]  mux_sel_o,
  output logic             vref_sel_o,
  output logic [RES_W-1:0] dac_code_o,
  input  logic             comp_i
);
  ctrl_a_t         wa;
  logic            wr_a, wr_b, start_req, abort_req, busy, tick;
  logic            en_q, ref_q, just_q;
  logic [CH_W-1:0] ch_q, conv_ch_q;
  logic [CS_W-1:0] cs_q, conv_cs_q;
  logic [RES_W-1:0] result;

  assign wa        = ctrl_a_t'(wr_data_i);
  assign wr_a      = wr_en_i && !wr_addr_i;
  assign wr_b      = wr_en_i &&  wr_addr_i;
  assign start_req = wr_a && wa.en && wa.go && !busy;
  assign abort_req = wr_a && busy && !(wa.en && wa.go);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; ref_q <= 1'b0; just_q <= 1'b0;
      ch_q <= '0; cs_q <= '0; conv_ch_q <= '0; conv_cs_q <= '0;
    end else begin
      if (wr_a) begin
        en_q   <= wa.en;
        ref_q  <= wa.vref;
        just_q <= wa.just;
        ch_q   <= wa.ch;
      end
      if (wr_b) cs_q <= wr_data_i[4+CS_W-1:4];
      if (start_req) begin
        conv_ch_q <= wa.ch;
        conv_cs_q <= cs_q;
      end
    end
  end

  adc_clk_gen #(.MAX_SHIFT(MAX_SHIFT), .CS_W(CS_W)) u_clk_gen (
    .clk_i, .rst_ni, .run_i(busy), .sel_i(conv_cs_q), .rc_clk_i, .tick_o(tick)
  );

  adc_sar_engine #(.RES_W(RES_W)) u_engine (
    .clk_i, .rst_ni, .start_i(start_req), .abort_i(abort_req), .tick_i(tick),
    .comp_i, .busy_o(busy), .done_o, .dac_code_o, .result_o(result)
  );

  assign {res_hi_o, res_lo_o} = place_result(result, just_q);
  assign ctrl_a_o   = {just_q, ref_q, 1'b0, ch_q, busy, en_q};
  assign ctrl_b_o   = {1'b0, cs_q, 4'b0000};
  assign mux_sel_o  = conv_ch_q;
  assign vref_sel_o = ref_q;

  p_start_gated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_a && !wa.en && !busy) |=> !busy);
  p_chan_latched_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(mux_sel_o));
  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req |=> ctrl_a_o[1]);
endmodule

// File: tb/adc_sar_ctrl_tb.sv
module adc_sar_ctrl_tb;
  logic       clk = 0, rst_n = 0, rc_clk = 0;
  logic       wr_en = 0, wr_addr = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] ctrl_a, ctrl_b, res_hi, res_lo;
  logic       done, vref_sel, comp;
  logic [2:0] mux_sel;
  logic [9:0] dac_code;
  logic [9:0] vin [8];
  logic [15:0] exp_q [$];
  int total = 0, bad = 0, done_cnt = 0;
  bit prev_done = 0;

  always #10 clk = ~clk;
  always #250 rc_clk = ~rc_clk;   // 25 system cycles per period
  localparam int RC_CYC = 25;

  assign comp = (vin[mux_sel] >= dac_code);

  adc_sar_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rc_clk_i(rc_clk), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .ctrl_a_o(ctrl_a), .ctrl_b_o(ctrl_b),
    .res_hi_o(res_hi), .res_lo_o(res_lo), .done_o(done), .mux_sel_o(mux_sel),
    .vref_sel_o(vref_sel), .dac_code_o(dac_code), .comp_i(comp)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] fmt(input logic [9:0] r, input logic right);
    if (right) return {6'b0, r[9:8], r[7:0]};
    return {r[9:2], r[1:0], 6'b0};
  endfunction

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  // writes clock select, then starts; returns at the negedge after the start edge
  task automatic start_conv(input int ch, input logic just, input logic [2:0] cs, input bit push);
    wr(1'b1, {1'b0, cs, 4'b0});
    @(negedge clk); wr_en = 1; wr_addr = 0; wr_data = {just, 1'b0, 1'b0, 3'(ch), 2'b11};
    if (push) exp_q.push_back(fmt(vin[ch], just));
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        done_cnt++;
        chk(!prev_done, "R13 done width", 1, 0);
        chk(ctrl_a[1] == 1'b0, "R13 busy at done", ctrl_a[1], 0);
        if (exp_q.size() == 0) chk(0, "R10 unexpected done", 1, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk({res_hi, res_lo} == e, "R6 R8 R9 result", {res_hi, res_lo}, e);
        end
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] snap;
    vin[0] = 10'h000; vin[1] = 10'h3FF; vin[2] = 10'h200; vin[3] = 10'h1FF;
    vin[4] = 10'h155; vin[5] = 10'h2AA; vin[6] = 10'h001; vin[7] = 10'h3FE;
    repeat (3) @(negedge clk);
    chk(ctrl_a == 0 && ctrl_b == 0 && res_hi == 0 && res_lo == 0 && !done,
        "R1 reset", {ctrl_a, ctrl_b}, 0);
    rst_n = 1;
    @(negedge clk);

    // R3: start without enable
    wr(1'b0, 8'h02);
    chk(ctrl_a[1] == 0, "R3 start ignored", ctrl_a, 8'h00);
    repeat (40) @(negedge clk);
    chk(done_cnt == 0, "R3 no done", done_cnt, 0);

    // R1 / R12 field layout
    wr(1'b0, 8'hD4);
    chk(ctrl_a == 8'hD4, "R1 byte A", ctrl_a, 8'hD4);
    chk(vref_sel == 1'b1, "R12 vref", vref_sel, 1);
    wr(1'b0, 8'h20);
    chk(ctrl_a == 8'h00, "R1 reserved bit", ctrl_a, 8'h00);
    chk(vref_sel == 1'b0, "R12 vref low", vref_sel, 0);
    wr(1'b1, 8'hFF);
    chk(ctrl_b == 8'h70, "R1 byte B", ctrl_b, 8'h70);

    // R4 divided modes, R2 busy, R6/R8/R9 via scoreboard
    begin
      logic [2:0] codes [6];
      codes[0] = 3'b000; codes[1] = 3'b100; codes[2] = 3'b001;
      codes[3] = 3'b101; codes[4] = 3'b010; codes[5] = 3'b110;
      for (int i = 0; i < 6; i++) begin
        start_conv(i, i[0], codes[i], 1);
        chk(ctrl_a[1] == 1, "R2 busy set", ctrl_a[1], 1);
        wait_done(cyc);
        chk(cyc == 11 * (2 << i), "R4 frame length", cyc, 11 * (2 << i));
      end
    end

    // R6 / R7 trial sequence at /64, channel 4 (0x155)
    start_conv(4, 1'b1, 3'b110, 1);
    cyc = 0;
    while (!done && cyc < 2000) begin
      if (cyc == 10)  chk(dac_code == 10'h000, "R7 hold code", dac_code, 0);
      if (cyc == 74)  chk(dac_code == 10'h200, "R6 first trial", dac_code, 10'h200);
      if (cyc == 138) chk(dac_code == 10'h100, "R6 second trial", dac_code, 10'h100);
      @(negedge clk); cyc++;
    end

    // R5 free-running clock, both codes
    for (int k = 0; k < 2; k++) begin
      start_conv(7 - k, 1'b0, k ? 3'b111 : 3'b011, 1);
      wait_done(cyc);
      chk(cyc >= 10 * RC_CYC && cyc <= 11 * RC_CYC + 8, "R5 rc frame", cyc, 11 * RC_CYC);
    end

    // R10 abort
    snap = {res_hi, res_lo};
    start_conv(1, 1'b0, 3'b010, 0);
    repeat (100) @(negedge clk);
    wr(1'b0, 8'h01);
    chk(ctrl_a[1] == 0, "R10 busy cleared", ctrl_a[1], 0);
    chk({res_hi, res_lo} == snap, "R10 result kept", {res_hi, res_lo}, snap);
    cyc = done_cnt;
    repeat (400) @(negedge clk);
    chk(done_cnt == cyc, "R10 no done after abort", done_cnt, cyc);

    // R11 channel latched
    start_conv(3, 1'b1, 3'b001, 1);
    repeat (20) @(negedge clk);
    wr(1'b0, {1'b1, 1'b0, 1'b0, 3'd5, 2'b11});
    chk(mux_sel == 3'd3, "R11 mux held", mux_sel, 3);
    chk(ctrl_a[4:2] == 3'd5, "R11 field readback", ctrl_a[4:2], 5);
    wait_done(cyc);
    @(negedge clk);

    // R8 / R9 explicit placement of 0x2AA
    start_conv(5, 1'b1, 3'b000, 1);
    wait_done(cyc);
    @(negedge clk);
    chk(res_hi == 8'h02 && res_lo == 8'hAA, "R8 right", {res_hi, res_lo}, 16'h02AA);
    wr(1'b0, {1'b0, 1'b0, 1'b0, 3'd5, 2'b01});
    chk(res_hi == 8'hAA && res_lo == 8'h80, "R9 left", {res_hi, res_lo}, 16'hAA80);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule